// File: doc/BRIEF.md
# FM Operator Phase Increment Calculator

This block turns a channel's pitch setting into the per-cycle step that an FM operator's phase accumulator adds. The pitch setting has two parts: a 10-bit frequency number and a 3-bit octave code. The operator adds a 4-bit frequency multiplier. The result is a 20-bit increment, returned together with the operator index that came with the request.

The register-write logic issues one request for each operator it affects. That means both operators of a channel on any frequency write, plus the two partner operators when the channel is paired for four-operator synthesis. The block is a two-stage registered pipeline. It takes a new request on every clock and never stalls. The octave shift is done in the first stage and the multiplier scaling in the second.

The octave code scales the frequency number by a power of two. Code 0 halves it, code 1 leaves it unchanged, and each higher code doubles it again. A multiplier of zero means a factor of one half. Any other multiplier value is an integer factor. The product is truncated to the output width.

Top module: `phase_step_calc`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `out_valid` is 0 and `out_inc` is 0.
- R2: `out_valid` is 1 exactly two rising clock edges after a rising edge that samples `in_valid` high. It is 0 two edges after an edge that samples `in_valid` low.
- R3: `out_idx` equals the `in_idx` that was presented with the request producing that result.
- R4: With octave code 0, the base value is the frequency number shifted right by one bit.
- R5: With octave code b from 1 to 7, the base value is the frequency number shifted left by b−1 bits.
- R6: With a nonzero multiplier m, `out_inc` is base × m, keeping only the low 20 bits.
- R7: With multiplier 0, `out_inc` is the base value shifted right by one bit (factor one half).
- R8: Requests presented on consecutive clocks each produce their own result on consecutive clocks, in order, with no stall.
- R9: When `out_valid` is 0, `out_inc` and `out_idx` keep the values of the most recent valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this clock |
| in_fnum | input | 10 | Channel frequency number |
| in_block | input | 3 | Channel octave code |
| in_mult | input | 4 | Operator frequency multiplier (0 means one half) |
| in_idx | input | 6 | Operator index carried with the request |
| out_valid | output | 1 | Result present |
| out_inc | output | 20 | Phase accumulator increment |
| out_idx | output | 6 | Operator index of the result |

## Verification
Two things happen in the same clock whenever requests arrive back to back. The first stage takes a new request while the second stage scales the request before it, and a result leaves on the same edge that a new request enters. The bench drives long runs of requests on consecutive clocks, chosen by a fixed-seed `$urandom` stream with occasional gaps. Each sampled output is compared with an expected value that a bench function computes for the request issued two clocks earlier. A mixed-up slot, a stall or a wrongly carried index therefore shows up as a mismatch in increment or index.

// File: rtl/phstep_pkg.sv
package phstep_pkg;

   // Implementation choice for the multiplier stage
   typedef enum logic [0:0] {
      MUL_NATIVE    = 1'b0,
      MUL_SHIFT_ADD = 1'b1
   } mul_style_e;

   // Width of the octave-shifted base: largest shift is (2**bw - 2)
   function automatic int base_width(input int fw, input int bw);
      return fw + (1 << bw) - 2;
   endfunction

endpackage

// File: rtl/phstep_octave_shift.sv
module phstep_octave_shift #(
   parameter int FNUM_W  = 10,
   parameter int BLOCK_W = 3,
   parameter int BASE_W  = phstep_pkg::base_width(FNUM_W, BLOCK_W)
) (
   input  logic [FNUM_W-1:0]  fnum,
   input  logic [BLOCK_W-1:0] block,
   output logic [BASE_W-1:0]  base
);
   // Shift left by the octave code, then drop one bit:
   // code 0 halves, code b>0 shifts left by b-1.
   localparam int EXT_W = BASE_W + 1;
   localparam int PAD_W = EXT_W - FNUM_W;

   logic [EXT_W-1:0] stage [0:BLOCK_W];

   assign stage[0] = {{PAD_W{1'b0}}, fnum};

   generate
      for (genvar g = 0; g < BLOCK_W; g++) begin : g_barrel
         assign stage[g+1] = block[g] ? (stage[g] << (1 << g)) : stage[g];
      end
   endgenerate

   assign base = stage[BLOCK_W][EXT_W-1:1];

   initial begin
      assert (PAD_W >= 1) else $error("phstep_octave_shift: base width too small");
   end
endmodule

// File: rtl/phstep_scale.sv
module phstep_scale #(
   parameter int BASE_W = 16,
   parameter int MULT_W = 4,
   parameter int OUT_W  = 20,
   parameter phstep_pkg::mul_style_e MUL_STYLE = phstep_pkg::MUL_NATIVE
) (
   input  logic [BASE_W-1:0] base,
   input  logic [MULT_W-1:0] mult,
   output logic [OUT_W-1:0]  inc
);
   localparam int PROD_W = BASE_W + MULT_W;

   logic [PROD_W-1:0] product;
   logic [PROD_W-1:0] halved;
   logic [PROD_W-1:0] chosen;

   generate
      if (MUL_STYLE == phstep_pkg::MUL_NATIVE) begin : g_mul_native
         assign product = {{MULT_W{1'b0}}, base} * {{BASE_W{1'b0}}, mult};
      end else begin : g_mul_shift_add
         logic [PROD_W-1:0] partial [0:MULT_W];
         assign partial[0] = '0;
         for (genvar k = 0; k < MULT_W; k++) begin : g_term
            assign partial[k+1] = partial[k] +
               (mult[k] ? ({{MULT_W{1'b0}}, base} << k) : {PROD_W{1'b0}});
         end
         assign product = partial[MULT_W];
      end
   endgenerate

   // Multiplier zero stands for one half
   assign halved = {{(MULT_W+1){1'b0}}, base[BASE_W-1:1]};
   assign chosen = (mult == '0) ? halved : product;

   generate
      if (PROD_W >= OUT_W) begin : g_wrap
         assign inc = chosen[OUT_W-1:0];
      end else begin : g_extend
         assign inc = {{(OUT_W-PROD_W){1'b0}}, chosen};
      end
   endgenerate

   initial begin
      assert (BASE_W >= 2) else $error("phstep_scale: BASE_W must be at least 2");
      assert (MULT_W >= 1) else $error("phstep_scale: MULT_W must be at least 1");
   end
endmodule

// File: rtl/phstep_stage.sv
module phstep_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= in_data;
         end
      end
   end

   // Payload is held across bubbles
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));

   initial begin
      assert (W >= 1) else $error("phstep_stage: W must be positive");
   end
endmodule

// File: rtl/phase_step_calc.sv
module phase_step_calc #(
   parameter int FNUM_W  = 10,
   parameter int BLOCK_W = 3,
   parameter int MULT_W  = 4,
   parameter int IDX_W   = 6,
   parameter int OUT_W   = 20,
   parameter phstep_pkg::mul_style_e MUL_STYLE = phstep_pkg::MUL_NATIVE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [FNUM_W-1:0]  in_fnum,
   input  logic [BLOCK_W-1:0] in_block,
   input  logic [MULT_W-1:0]  in_mult,
   input  logic [IDX_W-1:0]   in_idx,
   output logic               out_valid,
   output logic [OUT_W-1:0]   out_inc,
   output logic [IDX_W-1:0]   out_idx
);
   localparam int BASE_W = phstep_pkg::base_width(FNUM_W, BLOCK_W);
   localparam int S1_W   = BASE_W + MULT_W + IDX_W;
   localparam int S2_W   = OUT_W + IDX_W;

   // Stage 1: octave shift
   logic [BASE_W-1:0] base_c;
   logic              s1_valid;
   logic [S1_W-1:0]   s1_data;
   logic [BASE_W-1:0] s1_base;
   logic [MULT_W-1:0] s1_mult;
   logic [IDX_W-1:0]  s1_idx;

   phstep_octave_shift #(
      .FNUM_W (FNUM_W),
      .BLOCK_W(BLOCK_W),
      .BASE_W (BASE_W)
   ) u_shift (
      .fnum (in_fnum),
      .block(in_block),
      .base (base_c)
   );

   phstep_stage #(.W(S1_W)) u_s1 (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  ({base_c, in_mult, in_idx}),
      .out_valid(s1_valid),
      .out_data (s1_data)
   );

   assign {s1_base, s1_mult, s1_idx} = s1_data;

   // Stage 2: multiplier scaling
   logic [OUT_W-1:0] inc_c;
   logic [S2_W-1:0]  s2_data;

   phstep_scale #(
      .BASE_W   (BASE_W),
      .MULT_W   (MULT_W),
      .OUT_W    (OUT_W),
      .MUL_STYLE(MUL_STYLE)
   ) u_scale (
      .base(s1_base),
      .mult(s1_mult),
      .inc (inc_c)
   );

   phstep_stage #(.W(S2_W)) u_s2 (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (s1_valid),
      .in_data  ({inc_c, s1_idx}),
      .out_valid(out_valid),
      .out_data (s2_data)
   );

   assign {out_inc, out_idx} = s2_data;

   // Elaboration checks
   initial begin
      assert (FNUM_W >= 2)  else $error("phase_step_calc: FNUM_W must be at least 2");
      assert (BLOCK_W >= 1 && BLOCK_W <= 4) else $error("phase_step_calc: BLOCK_W out of range");
      assert (IDX_W >= 1)   else $error("phase_step_calc: IDX_W must be positive");
      assert (OUT_W >= 2)   else $error("phase_step_calc: OUT_W must be at least 2");
   end

   // R1: reset leaves the output idle
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_inc == '0));

   // R2: fixed latency of two clocks
   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 out_valid);

   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(s1_valid));

   // R3: index travels with its request
   assert_idx_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ##2 (out_idx == $past(in_idx, 2)));

   // R4: octave 0 with unit multiplier halves the frequency number
   assert_octave_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_block == '0 && in_mult == MULT_W'(1)) |-> ##2
      (out_inc == OUT_W'($past(in_fnum, 2) >> 1)));

   // R7: multiplier 0 at octave 1 halves the frequency number
   assert_half_mult_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_block == BLOCK_W'(1) && in_mult == '0) |-> ##2
      (out_inc == OUT_W'($past(in_fnum, 2) >> 1)));

   // R8: consecutive requests give consecutive results
   assert_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && s1_valid) |=> (s1_valid && out_valid));
endmodule

// File: tb/phase_step_calc_tb.sv
module phase_step_calc_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [9:0]  in_fnum = '0;
   logic [2:0]  in_block = '0;
   logic [3:0]  in_mult = '0;
   logic [5:0]  in_idx = '0;
   logic        out_valid;
   logic [19:0] out_inc;
   logic [5:0]  out_idx;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   phase_step_calc u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fnum(in_fnum),
      .in_block(in_block), .in_mult(in_mult), .in_idx(in_idx),
      .out_valid(out_valid), .out_inc(out_inc), .out_idx(out_idx)
   );

   function automatic logic [19:0] ref_inc(input logic [9:0] f, input logic [2:0] b,
                                           input logic [3:0] m);
      logic [31:0] base;
      logic [31:0] r;
      base = (b == 3'd0) ? ({22'd0, f} >> 1) : ({22'd0, f} << (b - 3'd1));
      if (m == 4'd0) r = base >> 1;
      else           r = (base * {28'd0, m}) & 32'h000F_FFFF;
      return r[19:0];
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Two-deep history of issued requests
   bit          h1_v, h2_v;
   logic [19:0] h1_inc, h2_inc;
   logic [5:0]  h1_idx, h2_idx;
   string       h1_tag, h2_tag;
   logic [19:0] last_inc = '0;
   logic [5:0]  last_idx = '0;

   // Called on a falling edge: check the request from two falling edges ago, then drive
   task automatic step(input bit v, input logic [9:0] f, input logic [2:0] b,
                       input logic [3:0] m, input logic [5:0] i);
      string tag;
      if (h2_v) begin
         chk(out_valid == 1'b1, "R2 valid after two clocks", out_valid, 1);
         chk(out_idx == h2_idx, "R3 index", out_idx, h2_idx);
         chk(out_inc == h2_inc, h2_tag, out_inc, h2_inc);
         last_inc = h2_inc;
         last_idx = h2_idx;
      end else begin
         chk(out_valid == 1'b0, "R2 no result without request", out_valid, 0);
         chk(out_inc == last_inc, "R9 increment held", out_inc, last_inc);
         chk(out_idx == last_idx, "R9 index held", out_idx, last_idx);
      end
      if (m == 4'd0)      tag = "R7 half multiplier";
      else if (b == 3'd0) tag = "R4 octave zero";
      else                tag = "R5 R6 shift and multiply";
      if (v && h1_v) tag = {tag, " R8 back-to-back"};
      h2_v = h1_v; h2_inc = h1_inc; h2_idx = h1_idx; h2_tag = h1_tag;
      h1_v = v; h1_inc = ref_inc(f, b, m); h1_idx = i; h1_tag = tag;
      in_valid = v; in_fnum = f; in_block = b; in_mult = m; in_idx = i;
      @(negedge clk);
   endtask

   initial begin
      h1_v = 0; h2_v = 0; h1_inc = '0; h2_inc = '0; h1_idx = '0; h2_idx = '0;
      h1_tag = ""; h2_tag = "";
      void'($urandom(32'd1187));
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
      chk(out_inc == 20'd0, "R1 increment in reset", out_inc, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
      chk(out_inc == 20'd0, "R1 increment after reset", out_inc, 0);

      // Directed corners
      step(1, 10'h3FF, 3'd0, 4'd1, 6'd1);   // R4 odd fnum halved
      step(1, 10'h3FF, 3'd1, 4'd1, 6'd2);   // R5 unshifted
      step(1, 10'h3FF, 3'd7, 4'd15, 6'd3);  // R5 R6 maximum
      step(1, 10'h201, 3'd0, 4'd0, 6'd4);   // R7 with octave 0: quarter
      step(0, 10'h000, 3'd0, 4'd0, 6'd0);
      step(1, 10'h155, 3'd4, 4'd0, 6'd35);  // R7 halving after shift
      step(1, 10'h001, 3'd1, 4'd0, 6'd36);  // R7 result zero
      step(0, 10'h3FF, 3'd7, 4'd15, 6'd63); // R9 ignored inputs
      step(0, 10'h3FF, 3'd7, 4'd15, 6'd63);
      step(1, 10'h2AB, 3'd3, 4'd7, 6'd5);
      step(1, 10'h0FF, 3'd6, 4'd12, 6'd6);

      // Random traffic, mostly back to back
      for (int n = 0; n < 4000; n++) begin
         step(($urandom % 8) != 0, 10'($urandom), 3'($urandom), 4'($urandom),
              6'($urandom));
      end
      step(0, '0, '0, '0, '0);
      step(0, '0, '0, '0, '0);
      step(0, '0, '0, '0, '0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule